// File: doc/BRIEF.md
# Interrupt Source Sensing and Pending Logic

This block turns a bank of raw interrupt lines into per-source pending bits for a downstream priority controller. Every line is first brought into the clock domain by a two-stage synchronizer. Each source then runs in one of four sensing modes. In the two level modes the pending bit simply mirrors the active level of the synchronized input. In the two edge modes the pending bit is a sticky latch that a detected transition sets.

Software drives the block through a single command channel. It carries an operation code and a bit vector. The operations set or clear enable-mask bits, and force or remove latched pending bits, which gives software-raised interrupts. A separate configuration strobe writes the sensing mode of one source.

When the priority controller takes an interrupt, it sends an acknowledge pulse with the source number. That pulse clears the latch of an edge-mode source. Source 0 is the fast source and keeps its pending bit through an acknowledge. The synchronized inputs, the enable mask and the pending vector are all brought out as 32-bit status words.

Top module: `irq_sense`

## Requirements
- R1: In mode 2'b00 (high level) a source's pending bit equals its synchronized input.
- R2: In mode 2'b01 (low level) a source's pending bit is the inverse of its synchronized input.
- R3: In mode 2'b10 (rising edge) a 0-to-1 change of the synchronized input sets a latched pending bit. The bit stays set after the input falls again.
- R4: In mode 2'b11 (falling edge) a 1-to-0 change of the synchronized input sets the latched pending bit. A rising change does not set it.
- R5: `raw_status` and the level-mode pending bits reflect `irq_raw` two cycles after it is sampled. Edge-mode pending bits reflect a transition three cycles after `irq_raw` is sampled.
- R6: Command code 3'd1 sets every mask bit whose `cmd_bits` bit is 1. Mask bits whose `cmd_bits` bit is 0 keep their value, and the change is visible after one clock.
- R7: Command code 3'd2 clears every mask bit whose `cmd_bits` bit is 1. All other mask bits are untouched.
- R8: Command code 3'd3 sets the pending latch of each selected edge-mode source. It has no effect on a level-mode source.
- R9: Command code 3'd4 clears the pending latch of each selected edge-mode source, source 0 included.
- R10: An acknowledge of source n (n > 0) clears that source's edge-mode pending bit one clock later. It does not touch any other source.
- R11: An acknowledge does not change the pending bit of source 0 or of a level-mode source.
- R12: When a new edge is detected in the same cycle as the acknowledge of that source, the pending bit stays set.
- R13: After reset the mask is all zero, every mode is 2'b00, and the synchronizer and latches are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | 32 | Asynchronous raw interrupt lines |
| cfg_we | input | 1 | Write strobe for a source's sensing mode |
| cfg_src | input | 5 | Source whose mode is written |
| cfg_mode | input | 2 | Mode: 00 high, 01 low, 10 rise, 11 fall |
| cmd_op | input | 3 | 0 none, 1 mask set, 2 mask clear, 3 pending set, 4 pending clear |
| cmd_bits | input | 32 | Bit vector for the command |
| ack_valid | input | 1 | Acknowledge pulse from the priority controller |
| ack_src | input | 5 | Acknowledged source number |
| pending | output | 32 | Pending bit of each source |
| mask | output | 32 | Enable mask |
| raw_status | output | 32 | Synchronized input levels |

## Verification
Commands and acknowledges act on the clock edge where they are sampled. Their effect on the mask or the pending vector is read one cycle later. A change on `irq_raw` shows on `raw_status` and on level-mode pending after two edges. It shows on edge-mode pending after three edges.

The bench drives inputs on the falling edge. A reference model is advanced at each rising edge, and the outputs are compared at the next falling edge, so every result is read in exactly the cycle it becomes due. The directed cases count these edges one at a time and check before and after the due cycle. They also place an acknowledge exactly in the cycle in which an edge is detected.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    localparam int NSRC_DEF = 32;

    typedef enum logic [1:0] {
        SENSE_HIGH = 2'b00,
        SENSE_LOW  = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_FALL = 2'b11
    } sense_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_EN_SET  = 3'd1,
        OP_EN_CLR  = 3'd2,
        OP_PND_SET = 3'd3,
        OP_PND_CLR = 3'd4
    } cmd_op_e;

    function automatic logic is_edge(sense_e m);
        return m[1];
    endfunction

    function automatic logic level_hit(sense_e m, logic v);
        return (m == SENSE_HIGH) ? v : ~v;
    endfunction

    function automatic logic edge_hit(sense_e m, logic cur, logic prev);
        logic h;
        case (m)
            SENSE_RISE: h = cur & ~prev;
            SENSE_FALL: h = ~cur & prev;
            default:    h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;
    logic [1:0]   fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s2_q   <= '0;
            fill_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
        end
    end

    assign dout = s2_q;

    // R5: synchronized output lags the raw input by two clocks
    p_sync_delay_r5: assert property (@(posedge clk) disable iff (rst)
        (fill_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/irq_cmd.sv
module irq_cmd
    import irq_sense_pkg::*;
#(
    parameter int N     = 32,
    parameter int SRC_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [1:0]       cfg_mode,
    input  logic [2:0]       cmd_op,
    input  logic [N-1:0]     cmd_bits,
    input  logic             ack_valid,
    input  logic [SRC_W-1:0] ack_src,
    output sense_e           modes [N],
    output logic [N-1:0]     mask,
    output logic [N-1:0]     set_vec,
    output logic [N-1:0]     clr_vec
);
    logic [N-1:0] mask_q;
    logic [N-1:0] ack_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            for (int i = 0; i < N; i++) modes[i] <= SENSE_HIGH;
        end else begin
            if (cmd_op == OP_EN_SET) mask_q <= mask_q | cmd_bits;
            else if (cmd_op == OP_EN_CLR) mask_q <= mask_q & ~cmd_bits;
            if (cfg_we) modes[cfg_src] <= sense_e'(cfg_mode);
        end
    end

    always_comb begin
        ack_vec = '0;
        if (ack_valid && (ack_src != '0)) ack_vec[ack_src] = 1'b1;
        set_vec = (cmd_op == OP_PND_SET) ? cmd_bits : '0;
        clr_vec = ((cmd_op == OP_PND_CLR) ? cmd_bits : '0) | ack_vec;
    end

    assign mask = mask_q;

    p_en_set_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_EN_SET) |=> ((mask & $past(cmd_bits)) == $past(cmd_bits)));

    p_en_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_EN_CLR) |=> ((mask & $past(cmd_bits)) == '0));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(cmd_op == OP_EN_SET || cmd_op == OP_EN_CLR) |=> $stable(mask));

endmodule

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
    import irq_sense_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_e mode,
    input  logic   lvl,
    input  logic   sw_set,
    input  logic   clr,
    output logic   pend
);
    logic prev_q, latch_q, latch_d, hit;

    assign hit = edge_hit(mode, lvl, prev_q);

    always_comb begin
        if (is_edge(mode)) latch_d = (latch_q & ~clr) | sw_set | hit;
        else               latch_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= lvl;
            latch_q <= latch_d;
        end
    end

    assign pend = is_edge(mode) ? latch_q : level_hit(mode, lvl);

    // R3/R4/R12: a detected edge always leaves the bit pending
    p_edge_latch_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (!is_edge(mode) || pend));

    // R10: a clear with no competing set empties the latch
    p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !sw_set && !hit && is_edge(mode)) |=> (!is_edge(mode) || !pend));

endmodule

// File: rtl/irq_sense.sv
module irq_sense
    import irq_sense_pkg::*;
#(
    parameter int N_SRC = NSRC_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SRC-1:0]         irq_raw,
    input  logic                     cfg_we,
    input  logic [$clog2(N_SRC)-1:0] cfg_src,
    input  logic [1:0]               cfg_mode,
    input  logic [2:0]               cmd_op,
    input  logic [N_SRC-1:0]         cmd_bits,
    input  logic                     ack_valid,
    input  logic [$clog2(N_SRC)-1:0] ack_src,
    output logic [N_SRC-1:0]         pending,
    output logic [N_SRC-1:0]         mask,
    output logic [N_SRC-1:0]         raw_status
);
    localparam int SRC_W = $clog2(N_SRC);

    logic [N_SRC-1:0] sync_lvl, set_vec, clr_vec;
    sense_e           modes [N_SRC];

    irq_sync #(.W(N_SRC)) u_sync (
        .clk(clk), .rst(rst), .din(irq_raw), .dout(sync_lvl)
    );

    irq_cmd #(.N(N_SRC), .SRC_W(SRC_W)) u_cmd (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_mode(cfg_mode),
        .cmd_op(cmd_op), .cmd_bits(cmd_bits),
        .ack_valid(ack_valid), .ack_src(ack_src),
        .modes(modes), .mask(mask), .set_vec(set_vec), .clr_vec(clr_vec)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        irq_sense_cell u_cell (
            .clk(clk), .rst(rst), .mode(modes[g]), .lvl(sync_lvl[g]),
            .sw_set(set_vec[g]), .clr(clr_vec[g]), .pend(pending[g])
        );
    end

    assign raw_status = sync_lvl;

    // R11: acknowledging the fast source never drops it
    p_fast_kept_r11: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_src == '0 && cmd_op != OP_PND_CLR && !cfg_we
         && is_edge(modes[0]) && pending[0]) |=> pending[0]);

endmodule

// File: tb/irq_sense_bench.sv
module irq_sense_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_raw = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_src = '0;
    logic [1:0]  cfg_mode = '0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_bits = '0;
    logic        ack_valid = 1'b0;
    logic [4:0]  ack_src = '0;
    logic [31:0] pending, mask, raw_status;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R13";

    logic [31:0] m_s1, m_s2, m_prev, m_edge, m_en;
    logic [1:0]  m_mode [32];

    irq_sense u_irq_sense (
        .clk(clk), .rst(rst), .irq_raw(irq_raw),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_mode(cfg_mode),
        .cmd_op(cmd_op), .cmd_bits(cmd_bits),
        .ack_valid(ack_valid), .ack_src(ack_src),
        .pending(pending), .mask(mask), .raw_status(raw_status)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pending();
        logic [31:0] p;
        for (int i = 0; i < 32; i++) begin
            if (m_mode[i][1])          p[i] = m_edge[i];
            else if (m_mode[i] == 2'b00) p[i] = m_s2[i];
            else                       p[i] = ~m_s2[i];
        end
        return p;
    endfunction

    task automatic tick();
        logic [31:0] det, setv, clrv, nedge;
        @(posedge clk);
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_edge = '0; m_en = '0;
            for (int i = 0; i < 32; i++) m_mode[i] = 2'b00;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (m_mode[i] == 2'b10)      det[i] = m_s2[i] & ~m_prev[i];
                else if (m_mode[i] == 2'b11) det[i] = ~m_s2[i] & m_prev[i];
                else                         det[i] = 1'b0;
            end
            setv = (cmd_op == 3'd3) ? cmd_bits : '0;
            clrv = (cmd_op == 3'd4) ? cmd_bits : '0;
            if (ack_valid && ack_src != 0) clrv[ack_src] = 1'b1;
            for (int i = 0; i < 32; i++)
                nedge[i] = m_mode[i][1] ? ((m_edge[i] & ~clrv[i]) | setv[i] | det[i]) : 1'b0;
            m_edge = nedge;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = irq_raw;
            if (cmd_op == 3'd1) m_en = m_en | cmd_bits;
            if (cmd_op == 3'd2) m_en = m_en & ~cmd_bits;
            if (cfg_we) m_mode[cfg_src] = cfg_mode;
        end
        @(negedge clk);
        if (!rst) begin
            chk("R5", raw_status, m_s2);
            chk("R6", mask, m_en);
            chk(cur_req, pending, exp_pending());
        end
        cfg_we = 1'b0; cmd_op = 3'd0; ack_valid = 1'b0;
    endtask

    task automatic set_mode(int src, logic [1:0] m);
        cfg_we = 1'b1; cfg_src = 5'(src); cfg_mode = m;
        tick();
    endtask

    task automatic do_op(logic [2:0] op, logic [31:0] bits);
        cmd_op = op; cmd_bits = bits;
        tick();
    endtask

    task automatic do_ack(int src);
        ack_valid = 1'b1; ack_src = 5'(src);
        tick();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R13: reset state
        chk("R13", pending, 32'h0);
        chk("R13", mask, 32'h0);
        chk("R13", raw_status, 32'h0);

        cur_req = "R6";
        do_op(3'd1, 32'h0000_00F0); chk("R6", mask, 32'h0000_00F0);
        do_op(3'd1, 32'h0000_0001); chk("R6", mask, 32'h0000_00F1);
        cur_req = "R7";
        do_op(3'd2, 32'h0000_0010); chk("R7", mask, 32'h0000_00E1);

        cur_req = "R1";
        irq_raw[5] = 1'b1;
        tick(); chk("R5", 32'(pending[5]), 32'd0);
        tick(); chk("R1", 32'(pending[5]), 32'd1);
        chk("R5", 32'(raw_status[5]), 32'd1);

        cur_req = "R2";
        set_mode(6, 2'b01); chk("R2", 32'(pending[6]), 32'd1);
        irq_raw[6] = 1'b1; tick(); tick();
        chk("R2", 32'(pending[6]), 32'd0);

        cur_req = "R3";
        set_mode(7, 2'b10);
        irq_raw[7] = 1'b1; tick(); tick();
        chk("R5", 32'(pending[7]), 32'd0);
        tick(); chk("R3", 32'(pending[7]), 32'd1);
        irq_raw[7] = 1'b0; tick(); tick(); tick();
        chk("R3", 32'(pending[7]), 32'd1);

        cur_req = "R10";
        do_ack(7);
        chk("R10", 32'(pending[7]), 32'd0);
        chk("R10", 32'(pending[5]), 32'd1);

        cur_req = "R4";
        set_mode(8, 2'b11);
        irq_raw[8] = 1'b1; tick(); tick(); tick();
        chk("R4", 32'(pending[8]), 32'd0);
        irq_raw[8] = 1'b0; tick(); tick(); tick();
        chk("R4", 32'(pending[8]), 32'd1);

        cur_req = "R11";
        do_ack(5); chk("R11", 32'(pending[5]), 32'd1);
        set_mode(0, 2'b10);
        irq_raw[0] = 1'b1; tick(); tick(); tick();
        chk("R11", 32'(pending[0]), 32'd1);
        do_ack(0); chk("R11", 32'(pending[0]), 32'd1);
        tick(); chk("R11", 32'(pending[0]), 32'd1);

        cur_req = "R9";
        do_op(3'd4, 32'h0000_0001); chk("R9", 32'(pending[0]), 32'd0);
        do_op(3'd4, 32'h0000_0100); chk("R9", 32'(pending[8]), 32'd0);

        cur_req = "R8";
        set_mode(9, 2'b10);
        do_op(3'd3, 32'h0000_0200); chk("R8", 32'(pending[9]), 32'd1);
        do_op(3'd3, 32'h0000_0400); chk("R8", 32'(pending[10]), 32'd0);

        cur_req = "R12";
        set_mode(11, 2'b10);
        irq_raw[11] = 1'b1; tick(); tick();
        ack_valid = 1'b1; ack_src = 5'd11;
        tick(); chk("R12", 32'(pending[11]), 32'd1);
        do_ack(11); chk("R12", 32'(pending[11]), 32'd0);

        cur_req = "R3";
        for (int n = 0; n < 4000; n++) begin
            irq_raw = irq_raw ^ ($urandom & $urandom & $urandom);
            if (($urandom % 4) == 0) begin
                cfg_we = 1'b1; cfg_src = 5'($urandom); cfg_mode = 2'($urandom);
            end
            if (($urandom % 3) == 0) begin
                cmd_op = 3'($urandom % 5); cmd_bits = $urandom & $urandom;
            end
            if (($urandom % 3) == 0) begin
                ack_valid = 1'b1; ack_src = 5'($urandom);
            end
            tick();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule